// File: doc/BRIEF.md
# Dual-Word Load Execution Sequencer

This block carries out one 32-bit load-pair instruction from start to finish. A caller hands it the raw instruction word, the value of the base register, the value of the index register and a flag that says whether the instruction's condition passed. The block checks that the word is a legal load-pair encoding. It then forms the offset address and the access address, fetches two 32-bit words through a valid/ready memory port and returns both words with their destination register numbers. When the addressing mode updates the base register, it also returns the value to write back.

When the access address is a multiple of 8, the block uses a single 64-bit read and places the two halves according to the endianness input. For any other address it issues two 32-bit reads, one after the other. The condition flags are never touched. A failed condition retires the instruction without any memory traffic. A malformed encoding raises an undefined-instruction pulse instead.

The control is one state machine with six states. S_IDLE waits for `start`. From there, an accepted instruction goes to S_REQ_A. A rejected or condition-failed instruction stays in S_IDLE and raises a one-cycle `undef` or `skip`. S_REQ_A presents the first request and moves to S_WAIT_A when `mreq_ready` is high. S_WAIT_A waits for a response. It then moves to S_DONE if the access was aligned, or to S_REQ_B if it was not. S_REQ_B presents the second word request at address plus 4 and moves to S_WAIT_B on `mreq_ready`. S_WAIT_B moves to S_DONE on the response. S_DONE drives `done` for one cycle and returns to S_IDLE.

Top module: `dword_load_seq`

## Requirements
- R1: An instruction is legal only when bits 27:25 are 000, bit 20 is 0 and bits 7:4 are 1101. Any other word gives a one-cycle `undef` pulse in the cycle after acceptance, and no memory request follows.
- R2: When bit 22 is 1, the offset is the 8-bit value {bits 11:8, bits 3:0}, zero-extended and shifted left by 2.
- R3: When bit 22 is 0, the offset is `index_val`. In that form, bits 11:8 must be zero, otherwise the instruction gives `undef`.
- R4: The offset address is base plus offset when bit 23 is 1 and base minus offset when bit 23 is 0. The arithmetic is modulo 2^32, so a result past either end wraps and no error is raised.
- R5: The access address is the offset address when bit 24 is 1, and the unmodified base when bit 24 is 0.
- R6: `wb_en` is high with `done` when bit 21 is 1 or bit 24 is 0. At that point `wb_data` is the offset address and `wb_idx` is bits 19:16.
- R7: An access address with its low three bits zero produces exactly one request, with `mreq_dword`=1 at that address. With `big_endian`=0, the first word is response bits 31:0 and the second is bits 63:32. With `big_endian`=1, the two halves are swapped.
- R8: Any other access address produces two requests with `mreq_dword`=0, first at the address and then at the address plus 4. The first and second words are taken from bits 31:0 of the first and second responses.
- R9: `first_idx` is bits 15:12 and `second_idx` is `first_idx`+1. An odd value in bits 15:12 gives `undef`.
- R10: With `cond_ok`=0 and a legal word, `skip` pulses for one cycle. No request, no `done` and no write-back follow.
- R11: `busy` is high from the cycle after acceptance through the `done` cycle, and `done` lasts exactly one cycle. A `start` that arrives while `busy` is high is ignored.
- R12: A request that is not accepted keeps `mreq_valid`, `mreq_addr` and `mreq_dword` unchanged until `mreq_ready` is high.
- R13: A base field of 1111 (the PC-relative literal form) is executed normally without write-back. Combined with any write-back mode, it gives `undef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction offered; taken when not busy |
| insn | input | 32 | Raw instruction word |
| cond_ok | input | 1 | Condition of the instruction passed |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value (register-offset form) |
| big_endian | input | 1 | Endianness for the 64-bit access |
| busy | output | 1 | Instruction in flight |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_addr | output | 32 | Request byte address |
| mreq_dword | output | 1 | 1: 64-bit read, 0: 32-bit read |
| mrsp_valid | input | 1 | Read response valid |
| mrsp_data | input | 64 | Read data; 32-bit reads return in bits 31:0 |
| done | output | 1 | Result valid strobe |
| first_idx | output | 4 | First destination register number |
| first_data | output | 32 | First destination value |
| second_idx | output | 4 | Second destination register number |
| second_data | output | 32 | Second destination value |
| wb_en | output | 1 | Base write-back valid (with done) |
| wb_idx | output | 4 | Base register number |
| wb_data | output | 32 | Base write-back value |
| undef | output | 1 | Undefined-instruction pulse |
| skip | output | 1 | Condition-failed retire pulse |

## Verification
The bench sweeps every combination of the three addressing bits against both offset forms, both endianness settings and several base and offset values. These include values that wrap past zero and past the top of the address space. The expected access address decides whether one 64-bit read or two 32-bit reads must appear. The sweep therefore separates aligned from unaligned sequencing, pre-indexed from post-indexed addressing, and swapped from unswapped halves. Memory returns a distinct pattern per address, so the data checks show which address and which half fed each destination. The memory stalls `mreq_ready` and varies response latency throughout, and some runs send a stray `start` while the block is busy. Separate cases cover each reject path, condition failure and the literal base field.

// File: rtl/dld_pkg.sv
package dld_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ_A,
        S_WAIT_A,
        S_REQ_B,
        S_WAIT_B,
        S_DONE
    } dld_state_e;

    localparam int REG_IDX_W = 4;
    localparam logic [REG_IDX_W-1:0] LITERAL_BASE = '1;

    // Decoded view of one load-pair instruction word.
    typedef struct packed {
        logic                 pre_index;
        logic                 add_off;
        logic                 imm_form;
        logic                 wback;
        logic [REG_IDX_W-1:0] base_idx;
        logic [REG_IDX_W-1:0] dst_idx;
        logic [7:0]           imm8;
    } dld_fields_t;

endpackage

// File: rtl/dld_decode.sv
module dld_decode
    import dld_pkg::*;
(
    input  logic [31:0]  insn,
    output dld_fields_t  fields,
    output logic         reject
);

    logic class_ok;
    logic reg_form_bad;
    logic odd_dst;
    logic literal_wb;
    logic unused_cond;

    assign unused_cond = ^insn[31:28];

    always_comb begin
        fields.pre_index = insn[24];
        fields.add_off   = insn[23];
        fields.imm_form  = insn[22];
        fields.wback     = insn[21] | ~insn[24];
        fields.base_idx  = insn[19:16];
        fields.dst_idx   = insn[15:12];
        fields.imm8      = {insn[11:8], insn[3:0]};

        class_ok     = (insn[27:25] == 3'b000) && !insn[20] && (insn[7:4] == 4'b1101);
        reg_form_bad = !insn[22] && (insn[11:8] != 4'd0);
        odd_dst      = insn[12];
        literal_wb   = (insn[19:16] == LITERAL_BASE) && fields.wback;
        reject       = !class_ok || reg_form_bad || odd_dst || literal_wb;
    end

endmodule

// File: rtl/dld_addr_gen.sv
module dld_addr_gen
    import dld_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  dld_fields_t       fields,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    output logic [XLEN-1:0]   off_addr,
    output logic [XLEN-1:0]   acc_addr,
    output logic              dw_aligned
);

    localparam int WORD_BYTES = XLEN / 8;
    localparam int PAIR_BYTES = 2 * WORD_BYTES;
    localparam int ALIGN_BITS = $clog2(PAIR_BYTES);

    logic [XLEN-1:0] offset;

    always_comb begin
        if (fields.imm_form) begin
            offset = {{(XLEN-10){1'b0}}, fields.imm8, 2'b00};
        end else begin
            offset = index_val;
        end
        off_addr   = fields.add_off ? (base_val + offset) : (base_val - offset);
        acc_addr   = fields.pre_index ? off_addr : base_val;
        dw_aligned = (acc_addr[ALIGN_BITS-1:0] == '0);
    end

endmodule

// File: rtl/dld_assemble.sv
module dld_assemble #(
    parameter int XLEN = 32
) (
    input  logic              big_endian,
    input  logic [2*XLEN-1:0] rsp_data,
    output logic [XLEN-1:0]   word_first,
    output logic [XLEN-1:0]   word_second
);

    logic [XLEN-1:0] low_half;
    logic [XLEN-1:0] high_half;

    assign low_half  = rsp_data[XLEN-1:0];
    assign high_half = rsp_data[2*XLEN-1:XLEN];

    always_comb begin
        if (big_endian) begin
            word_first  = high_half;
            word_second = low_half;
        end else begin
            word_first  = low_half;
            word_second = high_half;
        end
    end

endmodule

// File: rtl/dword_load_seq.sv
module dword_load_seq
    import dld_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = REG_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       insn,
    input  logic              cond_ok,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    input  logic              big_endian,
    output logic              busy,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [XLEN-1:0]   mreq_addr,
    output logic              mreq_dword,
    input  logic              mrsp_valid,
    input  logic [2*XLEN-1:0] mrsp_data,
    output logic              done,
    output logic [IDX_W-1:0]  first_idx,
    output logic [XLEN-1:0]   first_data,
    output logic [IDX_W-1:0]  second_idx,
    output logic [XLEN-1:0]   second_data,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              undef,
    output logic              skip
);

    localparam int WORD_BYTES = XLEN / 8;

    dld_state_e state_q, state_d;

    dld_fields_t     dec_fields;
    logic            dec_reject;
    logic [XLEN-1:0] calc_off_addr;
    logic [XLEN-1:0] calc_acc_addr;
    logic            calc_aligned;
    logic [XLEN-1:0] asm_first;
    logic [XLEN-1:0] asm_second;

    logic [XLEN-1:0]  acc_q;
    logic [XLEN-1:0]  wbval_q;
    logic             wb_q;
    logic             aligned_q;
    logic             endian_q;
    logic [IDX_W-1:0] dst_q;
    logic [IDX_W-1:0] base_q;
    logic [XLEN-1:0]  first_q;
    logic [XLEN-1:0]  second_q;
    logic             undef_q;
    logic             skip_q;

    logic accept;
    logic go;

    dld_decode u_decode (
        .insn   (insn),
        .fields (dec_fields),
        .reject (dec_reject)
    );

    dld_addr_gen #(.XLEN(XLEN)) u_addr (
        .fields     (dec_fields),
        .base_val   (base_val),
        .index_val  (index_val),
        .off_addr   (calc_off_addr),
        .acc_addr   (calc_acc_addr),
        .dw_aligned (calc_aligned)
    );

    dld_assemble #(.XLEN(XLEN)) u_asm (
        .big_endian  (endian_q),
        .rsp_data    (mrsp_data),
        .word_first  (asm_first),
        .word_second (asm_second)
    );

    assign accept = (state_q == S_IDLE) && start;
    assign go     = accept && !dec_reject && cond_ok;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (go)         state_d = S_REQ_A;
            S_REQ_A:  if (mreq_ready) state_d = S_WAIT_A;
            S_WAIT_A: if (mrsp_valid) state_d = aligned_q ? S_DONE : S_REQ_B;
            S_REQ_B:  if (mreq_ready) state_d = S_WAIT_B;
            S_WAIT_B: if (mrsp_valid) state_d = S_DONE;
            S_DONE:                   state_d = S_IDLE;
            default:                  state_d = S_IDLE;
        endcase
    end

    // Datapath and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            wbval_q   <= '0;
            wb_q      <= 1'b0;
            aligned_q <= 1'b0;
            endian_q  <= 1'b0;
            dst_q     <= '0;
            base_q    <= '0;
            first_q   <= '0;
            second_q  <= '0;
            undef_q   <= 1'b0;
            skip_q    <= 1'b0;
        end else begin
            undef_q <= accept && dec_reject;
            skip_q  <= accept && !dec_reject && !cond_ok;
            unique case (state_q)
                S_IDLE: begin
                    if (go) begin
                        acc_q     <= calc_acc_addr;
                        wbval_q   <= calc_off_addr;
                        wb_q      <= dec_fields.wback;
                        aligned_q <= calc_aligned;
                        endian_q  <= big_endian;
                        dst_q     <= dec_fields.dst_idx;
                        base_q    <= dec_fields.base_idx;
                    end
                end
                S_WAIT_A: begin
                    if (mrsp_valid) begin
                        if (aligned_q) begin
                            first_q  <= asm_first;
                            second_q <= asm_second;
                        end else begin
                            first_q  <= mrsp_data[XLEN-1:0];
                        end
                    end
                end
                S_WAIT_B: begin
                    if (mrsp_valid) begin
                        second_q <= mrsp_data[XLEN-1:0];
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        busy        = (state_q != S_IDLE);
        mreq_valid  = (state_q == S_REQ_A) || (state_q == S_REQ_B);
        mreq_dword  = (state_q == S_REQ_A) && aligned_q;
        mreq_addr   = (state_q == S_REQ_B) ? (acc_q + XLEN'(WORD_BYTES)) : acc_q;
        done        = (state_q == S_DONE);
        first_idx   = dst_q;
        second_idx  = dst_q + IDX_W'(1);
        first_data  = first_q;
        second_data = second_q;
        wb_en       = done && wb_q;
        wb_idx      = base_q;
        wb_data     = wbval_q;
        undef       = undef_q;
        skip        = skip_q;
    end

endmodule

// File: rtl/dword_load_seq_chk.sv
module dword_load_seq_chk #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mreq_valid,
    input logic              mreq_ready,
    input logic [XLEN-1:0]   mreq_addr,
    input logic              mreq_dword,
    input logic              done,
    input logic [IDX_W-1:0]  first_idx,
    input logic [IDX_W-1:0]  second_idx,
    input logic              wb_en,
    input logic              undef,
    input logic              skip
);

    assert_req_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> busy);

    assert_done_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy && !mreq_valid);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_dword)));

    assert_dword_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && mreq_dword) |-> (mreq_addr[2:0] == 3'd0));

    assert_retire_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, undef, skip}));

    assert_undef_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!busy && !mreq_valid));

    assert_skip_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (!busy && !mreq_valid && !wb_en));

    assert_pair_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((second_idx == first_idx + IDX_W'(1)) && !first_idx[0]));

    assert_wb_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

endmodule

bind dword_load_seq dword_load_seq_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/dword_load_seq_bench.sv
module dword_load_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic        cond_ok = 1'b0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic        big_endian = 1'b0;
    logic        busy;
    logic        mreq_valid;
    logic        mreq_ready = 1'b0;
    logic [31:0] mreq_addr;
    logic        mreq_dword;
    logic        mrsp_valid = 1'b0;
    logic [63:0] mrsp_data = '0;
    logic        done;
    logic [3:0]  first_idx;
    logic [31:0] first_data;
    logic [3:0]  second_idx;
    logic [31:0] second_data;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic        undef;
    logic        skip;

    int tests = 0;
    int fails = 0;
    bit watchdog_hit = 0;

    int          req_n;
    logic [31:0] req_addr [4];
    logic        req_dw [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dword_load_seq u_dword_load_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .cond_ok(cond_ok),
        .base_val(base_val), .index_val(index_val), .big_endian(big_endian),
        .busy(busy), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
        .mreq_addr(mreq_addr), .mreq_dword(mreq_dword), .mrsp_valid(mrsp_valid),
        .mrsp_data(mrsp_data), .done(done), .first_idx(first_idx),
        .first_data(first_data), .second_idx(second_idx), .second_data(second_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .undef(undef), .skip(skip)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_insn(input bit p, input bit u, input bit immf, input bit w,
                                            input logic [3:0] rn, input logic [3:0] rt,
                                            input logic [7:0] imm8);
        return {4'hE, 3'b000, p, u, immf, w, 1'b0, rn, rt, imm8[7:4], 4'b1101, imm8[3:0]};
    endfunction

    // Memory responder: stalls ready, varies latency, checks request holding (R12).
    initial begin
        int stall_ctr = 0;
        int rsp_cnt = 0;
        logic [31:0] p_addr = '0;
        logic p_dw = 1'b0;
        bit prev_wait = 0;
        logic [31:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            mrsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    mrsp_valid = 1'b1;
                    mrsp_data = p_dw ? {mem_word(p_addr + 4), mem_word(p_addr)}
                                     : {32'hDEAD_BEEF, mem_word(p_addr)};
                end
            end
            if (prev_wait)
                chk(mreq_valid && mreq_addr == prev_addr, "R12 request held", {31'd0, mreq_valid, mreq_addr}, {31'd1, 1'b1, prev_addr});
            stall_ctr++;
            mreq_ready = (stall_ctr % 3) != 1;
            prev_wait = mreq_valid && !mreq_ready;
            prev_addr = mreq_addr;
            if (mreq_valid && mreq_ready && rst_n) begin
                if (req_n < 4) begin
                    req_addr[req_n] = mreq_addr;
                    req_dw[req_n] = mreq_dword;
                end
                req_n++;
                p_addr = mreq_addr;
                p_dw = mreq_dword;
                rsp_cnt = 1 + (stall_ctr % 2);
            end
        end
    end

    // Runs one instruction; kind: 0 expect done, 1 expect undef, 2 expect skip.
    task automatic run_op(input logic [31:0] w, input logic [31:0] b, input logic [31:0] ix,
                          input bit c, input bit be, input int kind, input bit inject,
                          input string tag);
        bit p, u, immf, wb, aligned;
        logic [31:0] off, oaddr, acc, e1, e2;
        int cyc;
        bit saw_undef;
        p = w[24]; u = w[23]; immf = w[22];
        wb = w[21] | ~w[24];
        off = immf ? {22'd0, w[11:8], w[3:0], 2'b00} : ix;
        oaddr = u ? b + off : b - off;
        acc = p ? oaddr : b;
        aligned = acc[2:0] == 3'd0;
        if (aligned) begin
            e1 = be ? mem_word(acc + 4) : mem_word(acc);
            e2 = be ? mem_word(acc) : mem_word(acc + 4);
        end else begin
            e1 = mem_word(acc);
            e2 = mem_word(acc + 4);
        end
        @(negedge clk);
        req_n = 0;
        start = 1'b1; insn = w; base_val = b; index_val = ix; cond_ok = c; big_endian = be;
        @(negedge clk);
        start = 1'b0; insn = 32'h0; big_endian = ~be;
        saw_undef = 0;
        if (kind == 0)
            chk(busy, {tag, " R11 busy after accept"}, busy, 1);
        cyc = 0;
        while (!(done || undef || skip) && cyc < 60) begin
            if (inject && cyc == 1) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            saw_undef |= undef;
            cyc++;
        end
        if (kind == 1) begin
            chk(undef && !done && !skip, {tag, " undef pulse"}, {done, undef, skip}, 3'b010);
            @(negedge clk);
            chk(req_n == 0 && !busy, {tag, " no request after undef"}, req_n, 0);
        end else if (kind == 2) begin
            chk(skip && !done && !undef, {tag, " R10 skip pulse"}, {done, undef, skip}, 3'b001);
            @(negedge clk);
            chk(req_n == 0 && !busy && !done, {tag, " R10 no request"}, req_n, 0);
        end else begin
            chk(done && busy && !undef && !saw_undef, {tag, " R11 done"}, {busy, done, undef}, 3'b110);
            if (aligned) begin
                chk(req_n == 1 && req_dw[0] && req_addr[0] == acc, {tag, " R7 single dword req"},
                    {req_n[30:0], req_dw[0], req_addr[0]}, {31'd1, 1'b1, acc});
            end else begin
                chk(req_n == 2 && !req_dw[0] && !req_dw[1] && req_addr[0] == acc,
                    {tag, " R8 first word req"}, {req_n[30:0], req_dw[0], req_addr[0]}, {31'd2, 1'b0, acc});
                chk(req_addr[1] == acc + 4, {tag, " R8 second word req"}, req_addr[1], acc + 4);
            end
            chk(first_data == e1 && second_data == e2, {tag, " R5 R7 R8 data"},
                {first_data, second_data}, {e1, e2});
            chk(first_idx == w[15:12] && second_idx == w[15:12] + 4'd1, {tag, " R9 indices"},
                {first_idx, second_idx}, {w[15:12], w[15:12] + 4'd1});
            chk(wb_en == wb && (!wb || (wb_data == oaddr && wb_idx == w[19:16])),
                {tag, " R4 R6 write-back"}, {wb_en, wb_idx, wb_data}, {wb, w[19:16], oaddr});
            @(negedge clk);
            chk(!done && !busy, {tag, " R11 single done"}, {done, busy}, 2'b00);
        end
    endtask

    task automatic run_all();
        logic [31:0] bases [5];
        logic [7:0]  imms [3];
        logic [31:0] idxs [3];
        bases[0] = 32'h0000_1000; bases[1] = 32'h0000_1004; bases[2] = 32'h0000_2002;
        bases[3] = 32'h0000_0004; bases[4] = 32'hFFFF_FFF8;
        imms[0] = 8'h00; imms[1] = 8'h05; imms[2] = 8'hFF;
        idxs[0] = 32'h0; idxs[1] = 32'h1C; idxs[2] = 32'h8000_0004;

        repeat (3) @(negedge clk);
        chk(!busy && !mreq_valid && !done && !undef && !skip, "R11 reset state",
            {busy, mreq_valid, done, undef, skip}, 5'b0);
        rst_n = 1'b1;

        // Sweep: R2 R3 R4 R5 R6 R7 R8 R9 R11
        for (int bi = 0; bi < 5; bi++)
            for (int oi = 0; oi < 3; oi++)
                for (int fm = 0; fm < 2; fm++)
                    for (int m = 0; m < 8; m++)
                        for (int be = 0; be < 2; be++) begin
                            logic [3:0] rt, rn;
                            logic [7:0] im;
                            rt = 4'((2 * (bi + oi + m)) % 14);
                            rn = 4'(8 + ((m + be) % 4));
                            im = fm ? imms[oi] : {4'h0, 4'(oi + 3)};
                            run_op(mk_insn(m[2], m[1], fm[0], m[0], rn, rt, im),
                                   bases[bi], idxs[oi], 1'b1, be[0], 0,
                                   ((bi + oi + m + be) % 7) == 0, "sweep");
                        end

        // R1: wrong class bits, load bit set, wrong marker
        run_op(32'hE3C0_00D0, 32'h100, 0, 1, 0, 1, 0, "R1 class bits");
        run_op(32'hE1D0_00D0, 32'h100, 0, 1, 0, 1, 0, "R1 bit20");
        run_op(32'hE1C0_00B0, 32'h100, 0, 1, 0, 1, 0, "R1 marker");
        // R3: register form with nonzero bits 11:8
        run_op(mk_insn(1, 1, 0, 0, 4'd2, 4'd4, 8'h12), 32'h100, 32'h8, 1, 0, 1, 0, "R3 reg form field");
        // R9: odd first destination
        run_op(mk_insn(1, 1, 1, 0, 4'd2, 4'd5, 8'h02), 32'h100, 0, 1, 0, 1, 0, "R9 odd dst");
        // R10: condition failed
        run_op(mk_insn(1, 1, 1, 1, 4'd2, 4'd4, 8'h02), 32'h100, 0, 0, 0, 2, 0, "R10 cond fail");
        run_op(mk_insn(0, 0, 0, 0, 4'd3, 4'd6, 8'h01), 32'h104, 32'h4, 0, 1, 2, 0, "R10 cond fail reg");
        // R13: literal base
        run_op(mk_insn(1, 1, 1, 0, 4'd15, 4'd0, 8'h03), 32'h8000, 0, 1, 0, 0, 0, "R13 literal");
        run_op(mk_insn(1, 0, 1, 0, 4'd15, 4'd2, 8'h02), 32'h8000, 0, 1, 1, 0, 0, "R13 literal down");
        run_op(mk_insn(1, 1, 1, 1, 4'd15, 4'd0, 8'h03), 32'h8000, 0, 1, 0, 1, 0, "R13 literal wb");
        run_op(mk_insn(0, 1, 1, 0, 4'd15, 4'd0, 8'h03), 32'h8000, 0, 1, 0, 1, 0, "R13 literal post");
        // R4: wrap below zero and above top
        run_op(mk_insn(1, 0, 1, 1, 4'd1, 4'd2, 8'hFF), 32'h0000_0008, 0, 1, 0, 0, 0, "R4 wrap down");
        run_op(mk_insn(1, 1, 0, 1, 4'd1, 4'd2, 8'h01), 32'hFFFF_FFFC, 32'h0000_0010, 1, 1, 0, 0, "R4 wrap up");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WATCHDOG_CYCLES) @(posedge clk);
                watchdog_hit = 1;
            end
        join_any
        disable fork;
        if (watchdog_hit) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=timeout expected=completion");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule